// File: doc/BRIEF.md
# Fixed-Range Memory-Type Address Decoder

This block keeps the memory-type codes for the lowest mebibyte of physical address space. That space is split into three segments, each with its own granularity. The low half uses 64 KiB ranges. The next quarter uses 16 KiB ranges. The top quarter uses 4 KiB ranges. All three segments are packed into one flat array of 88 type bytes. Each segment starts at a fixed offset in that array: 0, 8 and 24.

Software-side logic loads the array through a write port. Each write carries one 64-bit word, which holds eight consecutive type bytes. There are eleven such words, numbered 0 to 10. Word 0 covers the first segment. Words 1–2 cover the second segment. Words 3–10 cover the third segment.

The block has three combinational query ports:
- A lookup port turns a physical address into a byte index, a hit flag and the stored type byte.
- A map port turns a word number into the index of that word's first byte.
- An end port turns a byte index into the first address after that range, so that a walker can step from range to range.

Top module: `mtd_fixed_decoder`

## Requirements
- R1: After reset, every address below 0x100000 looks up with hit 1 and type 0.
- R2: An address below 0x80000 decodes to index address>>16 (indices 0–7).
- R3: An address in 0x80000–0xBFFFF decodes to index 8 + ((address−0x80000)>>14) (indices 8–23).
- R4: An address in 0xC0000–0xFFFFF decodes to index 24 + ((address−0xC0000)>>12) (indices 24–87).
- R5: An address at or above 0x100000 gives hit 0, index 0 and type 0.
- R6: A write with word number k from 0 to 10 replaces bytes 8k to 8k+7 at the clock edge. Byte 8k+j takes write-data bits [8j+7:8j]. A lookup shows the new value in the cycle after that edge.
- R7: A write leaves all bytes outside its own word unchanged. A write with a word number from 11 to 15 changes nothing.
- R8: The map port with word number k below 11 gives valid 1 and index 8k. Any other word number gives valid 0 and index 0.
- R9: For an index i below 88, the end port gives valid 1 and the end address. That address is segment start + ((i − segment first index + 1) << segment granularity exponent). The segment starts are 0x0, 0x80000 and 0xC0000. The first indices are 0, 8 and 24. The exponents are 16, 14 and 12. Any index from 88 up gives valid 0 and address 0.
- R10: When no write takes place, the lookup type depends only on the lookup address, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Word number to write (0–10 valid) |
| wr_data | input | 64 | Eight type bytes; the lowest byte goes to the lowest index |
| lk_addr | input | PA_W (32) | Physical address to look up |
| lk_hit | output | 1 | Address lies below 0x100000 |
| lk_idx | output | 7 | Byte index of the address |
| lk_type | output | 8 | Stored type byte at that index |
| map_sel | input | 4 | Word number to translate |
| map_valid | output | 1 | Word number exists |
| map_idx | output | 7 | First byte index of the word |
| end_idx | input | 7 | Range index to query |
| end_valid | output | 1 | Index lies below 88 |
| end_addr | output | PA_W (32) | First address after the range |

## Verification
A wrong segment boundary or shift appears at once on lk_idx. It shows up for every address in the affected segment, and the full address sweep reaches each of the 88 ranges. A corrupted storage byte only appears when the lookup address falls inside that range. For that reason, every write is followed by a sweep of the whole space, which catches stray writes into neighbouring words in the next cycle. Errors in the end-address arithmetic are exposed by sweeping all 128 values of end_idx.

// File: rtl/mtd_pkg.sv
package mtd_pkg;
  localparam int TYPE_W     = 8;
  localparam int UNIT_BYTES = 8;
  localparam int NUM_SEG    = 3;
  localparam int NUM_BYTES  = 88;
  localparam int NUM_UNITS  = NUM_BYTES / UNIT_BYTES;
  localparam int IDX_W      = $clog2(NUM_BYTES + 40);
  localparam int SEL_W      = $clog2(NUM_UNITS + 5);
  localparam int SPAN_END   = 'h100000;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TYPE_W-1:0] mtype_t;

  function automatic int seg_start(int s);
    case (s)
      0:       return 'h00000;
      1:       return 'h80000;
      default: return 'hC0000;
    endcase
  endfunction

  function automatic int seg_end(int s);
    case (s)
      0:       return 'h80000;
      1:       return 'hC0000;
      default: return SPAN_END;
    endcase
  endfunction

  function automatic int seg_shift(int s);
    case (s)
      0:       return 16;
      1:       return 14;
      default: return 12;
    endcase
  endfunction

  function automatic int seg_first(int s);
    case (s)
      0:       return 0;
      1:       return 8;
      default: return 24;
    endcase
  endfunction

  function automatic int seg_ranges(int s);
    return (seg_end(s) - seg_start(s)) >> seg_shift(s);
  endfunction

  // first byte index of a register word: segment offset + 8 * unit within segment
  function automatic int unit_first_idx(int k);
    int acc;
    int res;
    acc = 0;
    res = 0;
    for (int s = 0; s < NUM_SEG; s++) begin
      int n;
      n = seg_ranges(s) / UNIT_BYTES;
      if (k >= acc && k < acc + n) res = seg_first(s) + UNIT_BYTES * (k - acc);
      acc = acc + n;
    end
    return res;
  endfunction
endpackage

// File: rtl/mtd_addr_decode.sv
module mtd_addr_decode
  import mtd_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  logic [PA_W-1:0] addr,
  output logic            hit,
  output idx_t            idx
);
  logic [NUM_SEG-1:0] in_seg;
  idx_t               seg_idx [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [PA_W-1:0] ST   = PA_W'(seg_start(s));
    localparam logic [PA_W-1:0] EN   = PA_W'(seg_end(s));
    localparam int              SH   = seg_shift(s);
    localparam idx_t            BASE = IDX_W'(seg_first(s));
    logic [PA_W-1:0] offset;
    assign offset     = addr - ST;
    assign in_seg[s]  = (addr >= ST) && (addr < EN);
    assign seg_idx[s] = BASE + IDX_W'(offset >> SH);
  end

  always_comb begin
    hit = |in_seg;
    idx = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (in_seg[s]) idx = seg_idx[s];
    end
  end
endmodule

// File: rtl/mtd_type_store.sv
module mtd_type_store
  import mtd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [UNIT_BYTES*TYPE_W-1:0] wr_data,
  input  logic                         rd_en,
  input  idx_t                         rd_idx,
  output mtype_t                       rd_type
);
  logic [NUM_BYTES-1:0][TYPE_W-1:0] mem_q, mem_d;
  logic [NUM_UNITS-1:0]             unit_we;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_we[u] = wr_en && (wr_sel == SEL_W'(u));
  end

  always_comb begin
    mem_d = mem_q;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_we[u]) mem_d[u*UNIT_BYTES +: UNIT_BYTES] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (|unit_we) begin
      mem_q <= mem_d;
    end
  end

  always_comb begin
    rd_type = '0;
    if (rd_en && (rd_idx < IDX_W'(NUM_BYTES))) rd_type = mem_q[rd_idx];
  end
endmodule

// File: rtl/mtd_range_end.sv
module mtd_range_end
  import mtd_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  idx_t            idx,
  output logic            valid,
  output logic [PA_W-1:0] end_addr
);
  logic [NUM_SEG-1:0] in_seg;
  logic [PA_W-1:0]    seg_end_a [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [PA_W-1:0] ST   = PA_W'(seg_start(s));
    localparam int              SH   = seg_shift(s);
    localparam idx_t            BASE = IDX_W'(seg_first(s));
    localparam idx_t            LIM  = IDX_W'(seg_first(s) + seg_ranges(s));
    assign in_seg[s]    = (idx >= BASE) && (idx < LIM);
    assign seg_end_a[s] = ST + ((PA_W'(idx - BASE) + PA_W'(1)) << SH);
  end

  always_comb begin
    valid    = |in_seg;
    end_addr = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (in_seg[s]) end_addr = seg_end_a[s];
    end
  end
endmodule

// File: rtl/mtd_fixed_decoder.sv
module mtd_fixed_decoder
  import mtd_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [63:0]     wr_data,
  input  logic [PA_W-1:0] lk_addr,
  output logic            lk_hit,
  output logic [6:0]      lk_idx,
  output logic [7:0]      lk_type,
  input  logic [3:0]      map_sel,
  output logic            map_valid,
  output logic [6:0]      map_idx,
  input  logic [6:0]      end_idx,
  output logic            end_valid,
  output logic [PA_W-1:0] end_addr
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  mtd_addr_decode #(.PA_W(PA_W)) u_dec (
    .addr (lk_addr),
    .hit  (lk_hit),
    .idx  (lk_idx)
  );

  mtd_type_store u_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_en   (lk_hit),
    .rd_idx  (lk_idx),
    .rd_type (lk_type)
  );

  mtd_range_end #(.PA_W(PA_W)) u_end (
    .idx      (end_idx),
    .valid    (end_valid),
    .end_addr (end_addr)
  );

  idx_t unit_tab [NUM_UNITS];
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_map
    assign unit_tab[u] = IDX_W'(unit_first_idx(u));
  end

  always_comb begin
    map_valid = 1'b0;
    map_idx   = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (map_sel == SEL_W'(u)) begin
        map_valid = 1'b1;
        map_idx   = unit_tab[u];
      end
    end
  end
endmodule

// File: rtl/mtd_fixed_decoder_chk.sv
module mtd_fixed_decoder_chk
  import mtd_pkg::*;
#(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [3:0]      wr_sel,
  input logic [63:0]     wr_data,
  input logic [PA_W-1:0] lk_addr,
  input logic            lk_hit,
  input logic [6:0]      lk_idx,
  input logic [7:0]      lk_type,
  input logic            map_valid,
  input logic [6:0]      map_idx,
  input logic            end_valid,
  input logic [PA_W-1:0] end_addr
);
  localparam logic [PA_W-1:0] TOP_A = PA_W'(SPAN_END);
  logic [7:0] wr_byte_here;
  assign wr_byte_here = wr_data[8*lk_idx[2:0] +: 8];

  p_wr_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel < 4'd11 && lk_hit && lk_idx[6:3] == {1'b0, wr_sel[2:0]} && wr_sel[3] == lk_idx[6])
      |=> (!$stable(lk_addr) || lk_type == $past(wr_byte_here)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(lk_addr) || $stable(lk_type)));

  p_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_addr >= TOP_A) |-> (!lk_hit && lk_type == 8'd0 && lk_idx == 7'd0));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_idx < 7'd88));

  p_map_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> (map_idx[2:0] == 3'd0 && map_idx < 7'd88));

  p_end_gran_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |-> (end_addr[11:0] == 12'd0 && end_addr <= TOP_A && end_addr != '0));
endmodule

bind mtd_fixed_decoder mtd_fixed_decoder_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .lk_addr   (lk_addr),
  .lk_hit    (lk_hit),
  .lk_idx    (lk_idx),
  .lk_type   (lk_type),
  .map_valid (map_valid),
  .map_idx   (map_idx),
  .end_valid (end_valid),
  .end_addr  (end_addr)
);

// File: tb/mtd_fixed_decoder_test.sv
module mtd_fixed_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [63:0] wr_data;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic [6:0]  lk_idx;
  logic [7:0]  lk_type;
  logic [3:0]  map_sel;
  logic        map_valid;
  logic [6:0]  map_idx;
  logic [6:0]  end_idx;
  logic        end_valid;
  logic [31:0] end_addr;

  int   tests  = 0;
  int   failed = 0;
  bit   done   = 0;
  logic [7:0] img [88];

  always #10 clk = ~clk;

  mtd_fixed_decoder #(.PA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_type(lk_type),
    .map_sel(map_sel), .map_valid(map_valid), .map_idx(map_idx),
    .end_idx(end_idx), .end_valid(end_valid), .end_addr(end_addr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_idx(logic [31:0] a);
    if (a < 32'h80000)  return int'(a >> 16);
    if (a < 32'hC0000)  return 8 + int'((a - 32'h80000) >> 14);
    return 24 + int'((a - 32'hC0000) >> 12);
  endfunction

  function automatic string seg_req(logic [31:0] a);
    if (a < 32'h80000) return "R2";
    if (a < 32'hC0000) return "R3";
    return "R4";
  endfunction

  // full sweep below 1 MiB; every range visited several times
  task automatic sweep(string req_type, int salt);
    for (int k = 0; k < 1024; k++) begin
      logic [31:0] a;
      int e;
      a = (32'(k) << 10) | ((32'(k) * 32'h137 + 32'(salt)) & 32'h3FF);
      @(negedge clk);
      lk_addr = a;
      #1;
      e = exp_idx(a);
      chk(seg_req(a), {57'd0, lk_idx}, 64'(e));
      chk({seg_req(a), " hit"}, {63'd0, lk_hit}, 64'd1);
      chk(req_type, {56'd0, lk_type}, {56'd0, img[e]});
    end
  endtask

  task automatic do_write(logic [3:0] sel, logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 4'd11)
      for (int j = 0; j < 8; j++) img[int'(sel)*8 + j] = data[8*j +: 8];
  endtask

  function automatic logic [63:0] pattern(int k, int mul, int add);
    logic [63:0] d;
    for (int j = 0; j < 8; j++) d[8*j +: 8] = 8'((k*8 + j) * mul + add);
    return d;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      failed++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    lk_addr = '0; map_sel = '0; end_idx = '0;
    for (int i = 0; i < 88; i++) img[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents are zero everywhere
    sweep("R1", 5);

    // R6: load every word, then verify the whole space
    for (int k = 0; k < 11; k++) do_write(4'(k), pattern(k, 29, 3));
    sweep("R6", 17);

    // R7: out-of-range word numbers must not disturb anything
    for (int k = 11; k < 16; k++) do_write(4'(k), 64'hFFFF_FFFF_FFFF_FFFF);
    sweep("R7", 99);

    // R6/R7: rewrite a single word; neighbours keep their bytes
    do_write(4'd5, 64'hA5A5_0102_0304_F0E1);
    sweep("R7", 321);
    do_write(4'd0, pattern(0, 7, 200));
    do_write(4'd10, pattern(10, 13, 77));
    sweep("R6", 3);

    // R10: value held while no write and address constant
    @(negedge clk);
    lk_addr = 32'hFF123;
    #1;
    begin
      logic [7:0] t0;
      t0 = lk_type;
      repeat (3) @(negedge clk);
      #1;
      chk("R10", {56'd0, lk_type}, {56'd0, t0});
      chk("R10 value", {56'd0, lk_type}, {56'd0, img[exp_idx(32'hFF123)]});
    end

    // R5: addresses at and above 1 MiB
    begin
      logic [31:0] miss [5] = '{32'h100000, 32'h100FFF, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h123456};
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        lk_addr = miss[i];
        #1;
        chk("R5 hit", {63'd0, lk_hit}, 64'd0);
        chk("R5 idx", {57'd0, lk_idx}, 64'd0);
        chk("R5 type", {56'd0, lk_type}, 64'd0);
      end
    end

    // R8: word-number map
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      map_sel = 4'(k);
      #1;
      chk("R8 valid", {63'd0, map_valid}, (k < 11) ? 64'd1 : 64'd0);
      chk("R8 idx", {57'd0, map_idx}, (k < 11) ? 64'(8*k) : 64'd0);
    end

    // R9: range end addresses
    for (int i = 0; i < 128; i++) begin
      logic [31:0] e;
      if (i < 8)       e = 32'((i + 1) << 16);
      else if (i < 24) e = 32'h80000 + 32'((i - 7) << 14);
      else if (i < 88) e = 32'hC0000 + 32'((i - 23) << 12);
      else             e = 32'd0;
      @(negedge clk);
      end_idx = 7'(i);
      #1;
      chk("R9 valid", {63'd0, end_valid}, (i < 88) ? 64'd1 : 64'd0);
      chk("R9 addr", {32'd0, end_addr}, {32'd0, e});
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule